// File: doc/BRIEF.md
# SDRAM Low-Power Entry Manager

This block decides when an SDRAM device goes into a low-power state and when it comes back out. It sits beside the memory sequencer. The sequencer raises an access request and holds it until this block grants it. The sequencer then marks the end of the transfer with a one-cycle done pulse. In the meantime the block counts idle cycles against a selectable timeout. Once the timeout has run out, it asks for the programmed low-power command and drops the clock-enable pin. Depending on the mode, it also gates the SDRAM clock.

When a new request arrives while the device sleeps, the block raises clock-enable again. It stalls the request until the wake-up delay has passed, then grants it. After that access finishes, the device goes back to sleep on the same timeout. Deep power-down is allowed only when the device-type input marks a low-power part. The device leaves deep power-down only when software moves the mode away from deep power-down.

Top module: `sdram_lp_gate`

## Requirements
- R1: After reset, `cke` and `clkEn` are 1, `accGrant` is 0 while `accReq` is 0, and no command request is raised.
- R2: With `cfgMode` = 0 (off), `cke` stays 1 and no self-refresh, power-down or deep power-down request is raised, however long the bus stays idle.
- R3: With `cfgMode` = 1 (self-refresh), entry raises `selfRefReq` for exactly one cycle. From that cycle until the wake-up, `cke` = 0 and `clkEn` = 0.
- R4: With `cfgMode` = 2 (power-down), entry raises `pwrDownReq` for exactly one cycle. From that cycle until the wake-up, `cke` = 0 and `clkEn` = 1.
- R5: With `cfgMode` = 3 and `devLowPower` = 1, entry raises `deepPdReq` once and holds `cke` = 0 and `clkEn` = 0. Requests are not granted in this state. After `cfgMode` leaves 3, a pending request is granted `cfgExitDelay`+1 cycles later.
- R6: With `cfgMode` = 3 and `devLowPower` = 0 (standard SDRAM), the block behaves as if the mode were off.
- R7: `cfgTimeout` codes 0, 1 and 2 give idle thresholds of 0, IDLE_SHORT (64) and IDLE_LONG (128) cycles. Counting starts at the clock edge that samples the transfer-done pulse. `cke` stays 1 for threshold+1 cycles after that edge, then falls.
- R8: `cfgTimeout` code 3 behaves like code 0.
- R9: The idle count restarts from zero on every access request, so a granted access starts a fresh full wait. No low-power entry happens while a transfer is in progress, however long it lasts.
- R10: A request that arrives in self-refresh raises `cke` and `clkEn` on the next cycle. It is granted `cfgExitDelay`+1 cycles after it is first seen.
- R11: A request that arrives in power-down raises `cke` on the next cycle. It is granted two cycles after it is first seen.
- R12: A request seen in the awake idle state is granted in the same cycle. After each completed access the device re-enters the programmed low-power state, with one command request per entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accReq | input | 1 | Access request from sequencer, held until granted |
| xferDone | input | 1 | One-cycle pulse at the end of the granted transfer |
| cfgMode | input | 2 | Low-power mode: 0 off, 1 self-refresh, 2 power-down, 3 deep power-down |
| cfgTimeout | input | 2 | Idle timeout code: 0 none, 1 short, 2 long, 3 as 0 |
| devLowPower | input | 1 | 1 = low-power SDRAM device |
| cfgExitDelay | input | XSR_W | Self-refresh/deep exit delay in cycles |
| accGrant | output | 1 | Grant of the pending request |
| cke | output | 1 | SDRAM clock-enable pin |
| clkEn | output | 1 | Enable for the SDRAM clock output |
| selfRefReq | output | 1 | One-cycle self-refresh command request |
| pwrDownReq | output | 1 | One-cycle power-down command request |
| deepPdReq | output | 1 | One-cycle deep power-down command request |

## Verification
The bench builds the block with its default parameters: IDLE_SHORT = 64, IDLE_LONG = 128 and a 4-bit exit delay. This lets it measure the real short and long idle windows to the exact cycle, and check that an idle spell shorter than the window is cut off by a new request. The 4-bit delay lets it compare exit delays of 0, 3 and 5 against the grant latency. It also lets it hold a transfer open for longer than the long window to show that no entry happens.

// File: rtl/lp_gate_pkg.sv
package lp_gate_pkg;

  // Programmed low-power mode
  typedef enum logic [1:0] {
    LP_OFF   = 2'd0,
    LP_SELF  = 2'd1,
    LP_PDOWN = 2'd2,
    LP_DEEP  = 2'd3
  } lpMode_e;

  // Controller states
  typedef enum logic [2:0] {
    ST_ACTIVE = 3'd0,
    ST_BUSY   = 3'd1,
    ST_SELF   = 3'd2,
    ST_PDOWN  = 3'd3,
    ST_DEEP   = 3'd4,
    ST_WAKE   = 3'd5
  } lpState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic idleClr;
    logic idleInc;
    logic wakeLoadExit;
    logic wakeLoadOne;
    logic wakeDec;
  } dpStrobe_t;

endpackage

// File: rtl/lp_gate_dp.sv
module lp_gate_dp
  import lp_gate_pkg::*;
#(
  parameter int IDLE_SHORT = 64,
  parameter int IDLE_LONG  = 128,
  parameter int XSR_W      = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [1:0]       cfgMode,
  input  logic [1:0]       cfgTimeout,
  input  logic             devLowPower,
  input  logic [XSR_W-1:0] cfgExitDelay,
  output lpMode_e          effMode,
  output logic             idleHit,
  output logic             wakeZero
);

  localparam int IDLE_W = $clog2(IDLE_LONG + 1);
  localparam logic [IDLE_W-1:0] IDLE_MAX = IDLE_W'(IDLE_LONG);
  localparam logic [IDLE_W-1:0] THR_S    = IDLE_W'(IDLE_SHORT);
  localparam logic [XSR_W-1:0]  ONE_WAKE = XSR_W'(1);

  logic [IDLE_W-1:0] idleCnt;
  logic [IDLE_W-1:0] idleThr;
  logic [XSR_W-1:0]  wakeCnt;

  // Mode decode: deep power-down needs a low-power device
  always_comb begin
    if (cfgMode == 2'd3 && !devLowPower) effMode = LP_OFF;
    else                                 effMode = lpMode_e'(cfgMode);
  end

  // Timeout decode: code 3 behaves as code 0
  always_comb begin
    case (cfgTimeout)
      2'd1:    idleThr = THR_S;
      2'd2:    idleThr = IDLE_MAX;
      default: idleThr = '0;
    endcase
  end

  // Saturating idle counter
  always_ff @(posedge clk) begin
    if (!rstN)                                      idleCnt <= '0;
    else if (strobe.idleClr)                        idleCnt <= '0;
    else if (strobe.idleInc && idleCnt != IDLE_MAX) idleCnt <= idleCnt + 1'b1;
  end

  assign idleHit = (idleCnt >= idleThr);

  // Shared wake-up counter for both exit paths
  always_ff @(posedge clk) begin
    if (!rstN)                                  wakeCnt <= '0;
    else if (strobe.wakeLoadExit)               wakeCnt <= cfgExitDelay;
    else if (strobe.wakeLoadOne)                wakeCnt <= ONE_WAKE;
    else if (strobe.wakeDec && wakeCnt != '0)   wakeCnt <= wakeCnt - 1'b1;
  end

  assign wakeZero = (wakeCnt == '0);

endmodule

// File: rtl/lp_gate_ctrl.sv
module lp_gate_ctrl
  import lp_gate_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      accReq,
  input  logic      xferDone,
  input  lpMode_e   effMode,
  input  logic      idleHit,
  input  logic      wakeZero,
  output dpStrobe_t strobe,
  output logic      accGrant,
  output logic      cke,
  output logic      clkEn,
  output logic      selfRefReq,
  output logic      pwrDownReq,
  output logic      deepPdReq
);

  lpState_e state, stateNxt;
  logic     entryR, entryNxt;

  always_comb begin
    stateNxt = state;
    entryNxt = 1'b0;
    strobe   = '0;
    accGrant = 1'b0;
    unique case (state)
      ST_ACTIVE: begin
        if (accReq) begin
          accGrant       = 1'b1;
          strobe.idleClr = 1'b1;
          stateNxt       = ST_BUSY;
        end else if (effMode != LP_OFF && idleHit) begin
          strobe.idleClr = 1'b1;
          entryNxt       = 1'b1;
          case (effMode)
            LP_SELF:  stateNxt = ST_SELF;
            LP_PDOWN: stateNxt = ST_PDOWN;
            default:  stateNxt = ST_DEEP;
          endcase
        end else begin
          strobe.idleInc = 1'b1;
        end
      end
      ST_BUSY: begin
        strobe.idleClr = 1'b1;
        if (xferDone) stateNxt = ST_ACTIVE;
      end
      ST_SELF: begin
        strobe.idleClr = 1'b1;
        if (accReq) begin
          strobe.wakeLoadExit = 1'b1;
          stateNxt            = ST_WAKE;
        end
      end
      ST_PDOWN: begin
        strobe.idleClr = 1'b1;
        if (accReq) begin
          strobe.wakeLoadOne = 1'b1;
          stateNxt           = ST_WAKE;
        end
      end
      ST_DEEP: begin
        strobe.idleClr = 1'b1;
        if (effMode != LP_DEEP) begin
          strobe.wakeLoadExit = 1'b1;
          stateNxt            = ST_WAKE;
        end
      end
      ST_WAKE: begin
        strobe.idleClr = 1'b1;
        if (!wakeZero) begin
          strobe.wakeDec = 1'b1;
        end else if (accReq) begin
          accGrant = 1'b1;
          stateNxt = ST_BUSY;
        end else begin
          stateNxt = ST_ACTIVE;
        end
      end
      default: stateNxt = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_ACTIVE;
      entryR <= 1'b0;
    end else begin
      state  <= stateNxt;
      entryR <= entryNxt;
    end
  end

  assign cke        = !(state == ST_SELF || state == ST_PDOWN || state == ST_DEEP);
  assign clkEn      = !(state == ST_SELF || state == ST_DEEP);
  assign selfRefReq = entryR && (state == ST_SELF);
  assign pwrDownReq = entryR && (state == ST_PDOWN);
  assign deepPdReq  = entryR && (state == ST_DEEP);

endmodule

// File: rtl/sdram_lp_gate.sv
module sdram_lp_gate
  import lp_gate_pkg::*;
#(
  parameter int IDLE_SHORT = 64,
  parameter int IDLE_LONG  = 128,
  parameter int XSR_W      = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             accReq,
  input  logic             xferDone,
  input  logic [1:0]       cfgMode,
  input  logic [1:0]       cfgTimeout,
  input  logic             devLowPower,
  input  logic [XSR_W-1:0] cfgExitDelay,
  output logic             accGrant,
  output logic             cke,
  output logic             clkEn,
  output logic             selfRefReq,
  output logic             pwrDownReq,
  output logic             deepPdReq
);

  dpStrobe_t strobe;
  lpMode_e   effMode;
  logic      idleHit;
  logic      wakeZero;

  lp_gate_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .accReq     (accReq),
    .xferDone   (xferDone),
    .effMode    (effMode),
    .idleHit    (idleHit),
    .wakeZero   (wakeZero),
    .strobe     (strobe),
    .accGrant   (accGrant),
    .cke        (cke),
    .clkEn      (clkEn),
    .selfRefReq (selfRefReq),
    .pwrDownReq (pwrDownReq),
    .deepPdReq  (deepPdReq)
  );

  lp_gate_dp #(
    .IDLE_SHORT (IDLE_SHORT),
    .IDLE_LONG  (IDLE_LONG),
    .XSR_W      (XSR_W)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .cfgMode      (cfgMode),
    .cfgTimeout   (cfgTimeout),
    .devLowPower  (devLowPower),
    .cfgExitDelay (cfgExitDelay),
    .effMode      (effMode),
    .idleHit      (idleHit),
    .wakeZero     (wakeZero)
  );

endmodule

// File: rtl/lp_gate_chk.sv
module lp_gate_chk (
  input logic       clk,
  input logic       rstN,
  input logic       accReq,
  input logic       accGrant,
  input logic       cke,
  input logic       clkEn,
  input logic       selfRefReq,
  input logic       pwrDownReq,
  input logic       deepPdReq,
  input logic [1:0] cfgMode,
  input logic       devLowPower
);

  // R12: at most one command request at a time
  p_cmd_onehot_r12: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({selfRefReq, pwrDownReq, deepPdReq}));

  // R3: self-refresh request comes with pin and clock low
  p_self_pins_r3: assert property (@(posedge clk) disable iff (!rstN)
    selfRefReq |-> (!cke && !clkEn));

  // R4: power-down request keeps the clock running
  p_pdown_pins_r4: assert property (@(posedge clk) disable iff (!rstN)
    pwrDownReq |-> (!cke && clkEn));

  // R6: deep power-down only for a low-power device in mode 3
  p_deep_dev_r6: assert property (@(posedge clk) disable iff (!rstN)
    deepPdReq |-> ($past(devLowPower) && $past(cfgMode) == 2'd3));

  // R5: no grant while the device sleeps
  p_no_grant_asleep_r5: assert property (@(posedge clk) disable iff (!rstN)
    accGrant |-> (cke && clkEn));

  // R12: grant only answers a live request
  p_grant_req_r12: assert property (@(posedge clk) disable iff (!rstN)
    accGrant |-> accReq);

endmodule

bind sdram_lp_gate lp_gate_chk chk_i (
  .clk         (clk),
  .rstN        (rstN),
  .accReq      (accReq),
  .accGrant    (accGrant),
  .cke         (cke),
  .clkEn       (clkEn),
  .selfRefReq  (selfRefReq),
  .pwrDownReq  (pwrDownReq),
  .deepPdReq   (deepPdReq),
  .cfgMode     (cfgMode),
  .devLowPower (devLowPower)
);

// File: tb/sdram_lp_gate_tb_top.sv
module sdram_lp_gate_tb_top;

  localparam int XSR_W = 4;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             accReq = 1'b0;
  logic             xferDone = 1'b0;
  logic [1:0]       cfgMode = 2'd0;
  logic [1:0]       cfgTimeout = 2'd0;
  logic             devLowPower = 1'b0;
  logic [XSR_W-1:0] cfgExitDelay = 4'd5;
  logic accGrant, cke, clkEn, selfRefReq, pwrDownReq, deepPdReq;

  int checks = 0;
  int errors = 0;
  int srN = 0, pdN = 0, dpN = 0;

  always #2 clk = ~clk;

  sdram_lp_gate #(.XSR_W(XSR_W)) dut_i (
    .clk(clk), .rstN(rstN), .accReq(accReq), .xferDone(xferDone),
    .cfgMode(cfgMode), .cfgTimeout(cfgTimeout), .devLowPower(devLowPower),
    .cfgExitDelay(cfgExitDelay), .accGrant(accGrant), .cke(cke), .clkEn(clkEn),
    .selfRefReq(selfRefReq), .pwrDownReq(pwrDownReq), .deepPdReq(deepPdReq)
  );

  // Count command-request samples (a stuck pulse inflates the count)
  always @(negedge clk) begin
    if (rstN) begin
      if (selfRefReq) srN++;
      if (pwrDownReq) pdN++;
      if (deepPdReq)  dpN++;
    end
  end

  task automatic chkEq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Raise a request and count negedge samples until granted
  task automatic startAccess(output int waitN);
    @(negedge clk);
    accReq = 1'b1;
    #1;
    waitN = 0;
    while (!accGrant && waitN < 1000) begin
      @(negedge clk); #1;
      waitN++;
    end
  endtask

  task automatic finishAccess();
    @(negedge clk);
    accReq = 1'b0;
    repeat (2) @(negedge clk);
    xferDone = 1'b1;
    @(negedge clk);
    xferDone = 1'b0;
  endtask

  task automatic doAccess(output int waitN);
    startAccess(waitN);
    finishAccess();
  endtask

  // Cycles with cke high after the transfer-done edge
  task automatic measureIdle(output int n);
    n = 0;
    #1;
    while (cke && n < 1000) begin
      n++;
      @(negedge clk); #1;
    end
  endtask

  task automatic t_reset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    chkEq("R1 cke after reset", cke, 1);
    chkEq("R1 clkEn after reset", clkEn, 1);
    chkEq("R1 grant after reset", accGrant, 0);
    chkEq("R1 no command after reset", srN + pdN + dpN, 0);
  endtask

  task automatic t_disabled();
    int w, lowN;
    int base;
    base = srN + pdN + dpN;
    cfgMode = 2'd0; cfgTimeout = 2'd0;
    doAccess(w);
    lowN = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); #1;
      if (!cke) lowN++;
    end
    chkEq("R2 cke low samples in off mode", lowN, 0);
    chkEq("R2 commands in off mode", srN + pdN + dpN - base, 0);
  endtask

  task automatic t_powerdown();
    int w, n, pd0;
    cfgMode = 2'd2; cfgTimeout = 2'd1;
    doAccess(w);
    pd0 = pdN;
    measureIdle(n);
    chkEq("R7 short timeout window", n, 65);
    chkEq("R4 cke in power-down", cke, 0);
    chkEq("R4 clkEn in power-down", clkEn, 1);
    @(negedge clk);
    chkEq("R4 power-down request width", pdN - pd0, 1);
    cfgTimeout = 2'd2;
    doAccess(w);
    chkEq("R11 power-down wake grant latency", w, 2);
    measureIdle(n);
    chkEq("R7 long timeout window", n, 129);
    cfgTimeout = 2'd0;
    doAccess(w);
    pd0 = pdN;
    measureIdle(n);
    chkEq("R7 zero timeout window", n, 1);
    @(negedge clk);
    chkEq("R12 re-entry after access", pdN - pd0, 1);
    cfgTimeout = 2'd3;
    doAccess(w);
    measureIdle(n);
    chkEq("R8 reserved timeout as zero", n, 1);
  endtask

  task automatic t_idle_clear();
    int w, n, lowN, pd0;
    cfgMode = 2'd2; cfgTimeout = 2'd1;
    doAccess(w);
    lowN = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); #1;
      if (!cke) lowN++;
    end
    chkEq("R9 awake during partial idle", lowN, 0);
    doAccess(w);
    chkEq("R12 immediate grant when awake", w, 0);
    measureIdle(n);
    chkEq("R9 idle count restarted", n, 65);
    cfgTimeout = 2'd0;
    startAccess(w);
    @(negedge clk);
    accReq = 1'b0;
    pd0 = pdN;
    lowN = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); #1;
      if (!cke) lowN++;
    end
    chkEq("R9 no entry during long transfer", lowN + pdN - pd0, 0);
    @(negedge clk);
    xferDone = 1'b1;
    @(negedge clk);
    xferDone = 1'b0;
  endtask

  task automatic t_selfref();
    int w, n, sr0;
    cfgMode = 2'd1; cfgTimeout = 2'd0; cfgExitDelay = 4'd5;
    doAccess(w);
    sr0 = srN;
    measureIdle(n);
    chkEq("R3 cke in self-refresh", cke, 0);
    chkEq("R3 clkEn in self-refresh", clkEn, 0);
    @(negedge clk);
    chkEq("R3 self-refresh request width", srN - sr0, 1);
    startAccess(w);
    chkEq("R10 exit delay 5 grant latency", w, 6);
    chkEq("R10 cke on at grant", cke, 1);
    finishAccess();
    measureIdle(n);
    cfgExitDelay = 4'd0;
    doAccess(w);
    chkEq("R10 exit delay 0 grant latency", w, 1);
  endtask

  task automatic t_deep();
    int w, n, lowN, dp0, g;
    cfgMode = 2'd3; cfgTimeout = 2'd0; devLowPower = 1'b0; cfgExitDelay = 4'd3;
    doAccess(w);
    dp0 = dpN;
    lowN = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk); #1;
      if (!cke) lowN++;
    end
    chkEq("R6 standard device stays awake", lowN, 0);
    chkEq("R6 no deep request on standard device", dpN - dp0, 0);
    @(negedge clk);
    devLowPower = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chkEq("R5 cke in deep power-down", cke, 0);
    chkEq("R5 clkEn in deep power-down", clkEn, 0);
    chkEq("R5 deep request count", dpN - dp0, 1);
    @(negedge clk);
    accReq = 1'b1;
    g = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); #1;
      if (accGrant) g++;
    end
    chkEq("R5 no grant in deep power-down", g, 0);
    @(negedge clk);
    cfgMode = 2'd0;
    #1;
    n = 0;
    while (!accGrant && n < 1000) begin
      @(negedge clk); #1;
      n++;
    end
    chkEq("R5 deep exit grant latency", n, 4);
    finishAccess();
    measureIdle(n);
  endtask

  initial begin
    t_reset();
    t_disabled();
    t_powerdown();
    t_idle_clear();
    t_selfref();
    t_deep();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule